// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

A memory-mapped timer unit with four independent down-counters that share one interrupt controller. Software programs each channel through four word registers: a load value, a readable current count, a control word and a background-load value. A channel counts down on each prescaler tick. On its terminal count it either stops (one-shot), wraps to the all-ones value of its width (free-running) or reloads from its background-load value (periodic). In the last two cases it keeps running. The counters run on the register clock. Because the count goes downward, software inverts the value to get a rising time base.

Each terminal count sets the channel's raw interrupt bit. A mask register selects which raw bits reach the single interrupt output. A write-one-to-clear register drops raw bits. Each channel has its own prescaler with divide-by-1, 16 or 256 and a 16-bit or 32-bit count width. The register bus is a plain word-addressed port: a word index, a write strobe, write data and combinational read data.

Top module: `quad_down_timer`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, all channels are stopped and `irq_out` is low.
- R2: Word index 4+4n (byte offset 0x10+0x10n) starts channel n's group: word +0 load, +1 current value, +2 control, +3 background load; load, control and background load read back what was written (control in bits [7:0]).
- R3: A load write puts the value, cut to the selected width, into the counter on the write edge (taking precedence over a tick on that edge, which then raises no interrupt) and also copies the full value into the background-load register.
- R4: A background-load write alone leaves the counter untouched and only changes the value taken at the next periodic reload.
- R5: Control bit 7 enables the channel; with it clear the count holds and no interrupt is raised; when enabled, each tick lowers the count by one.
- R6: Control bits [3:2] pick the tick rate: 00 every cycle, 01 every 16th cycle, 10 and 11 every 256th cycle; the divider restarts when the channel is enabled or the field changes, so the first decrement lands on the 1st, 16th or 256th edge after that write.
- R7: Control bit 1 set selects a 32-bit count; clear selects 16 bits, and the value register then shows only the low 16 bits.
- R8: With bit 0 and bit 6 clear (free-running), a tick at count zero loads the all-ones value of the width and sets the raw interrupt bit.
- R9: With bit 0 clear and bit 6 set (periodic), a tick at count zero loads the background-load value and sets the raw interrupt bit.
- R10: With bit 0 set (one-shot), the tick that takes the count from 1 to 0 sets the raw bit; the count then stays at zero with no further interrupt, and the control word is left unchanged.
- R11: Word 0 is a read/write mask, word 1 the raw status, word 2 raw AND mask; bit n belongs to channel n, and `irq_out` is high exactly when any masked bit is set.
- R12: Writing ones to word 3 clears those raw bits; a terminal count on the same edge wins over the clear; word 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Word index of the accessed register |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
A register write takes effect on the rising edge that samples it, and read data is combinational. The bench therefore drives each write at a falling edge and reads in the low half of the following cycle. A divide-by-D channel decrements on the D-th edge after its enabling write. A raw bit is set on the same edge as the count change that ends a cycle, so it is visible with that count. The bench counts edges from the enabling write and samples at the edge just before each predicted change and just after it. Its reference functions give the count and the raw bit after n ticks for free-running, periodic and one-shot channels.

// File: rtl/qdt_pkg.sv
// Shared types and register offsets for the four-channel down-counting timer.
// Assumes word-addressed access; offsets below are word indices inside a group.
package qdt_pkg;

    localparam int CTRL_W = 8;

    // Tick rate selection held in control bits [3:2].
    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_SPARE  = 2'b11
    } presc_e;

    // Control word layout, most significant field first.
    typedef struct packed {
        logic       en;        // bit 7
        logic       periodic;  // bit 6
        logic [1:0] spare;     // bits 5:4
        presc_e     presc;     // bits 3:2
        logic       wide;      // bit 1
        logic       oneshot;   // bit 0
    } ctrl_t;

    // Word index inside a channel group.
    localparam logic [1:0] REG_LOAD  = 2'd0;
    localparam logic [1:0] REG_VALUE = 2'd1;
    localparam logic [1:0] REG_CTRL  = 2'd2;
    localparam logic [1:0] REG_BGL   = 2'd3;

    // Word index inside the interrupt group (group 0).
    localparam logic [1:0] IRQ_MASK  = 2'd0;
    localparam logic [1:0] IRQ_RAW   = 2'd1;
    localparam logic [1:0] IRQ_MSTAT = 2'd2;
    localparam logic [1:0] IRQ_CLEAR = 2'd3;

endpackage

// File: rtl/qdt_prescaler.sv
// Tick divider for one timer channel.
// Produces a one-cycle tick every cycle, every 2**SHORT_LOG cycles or every
// 2**LONG_LOG cycles. The spare code behaves as the long division.
// Assumes SHORT_LOG < LONG_LOG. A restart pulse zeroes the phase and
// suppresses the tick in that cycle.
module qdt_prescaler
    import qdt_pkg::*;
#(
    parameter int SHORT_LOG = 4,
    parameter int LONG_LOG  = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  logic   restart,
    input  presc_e sel,
    output logic   tick
);

    localparam logic [LONG_LOG-1:0] SHORT_LIM = LONG_LOG'((1 << SHORT_LOG) - 1);
    localparam logic [LONG_LOG-1:0] LONG_LIM  = '1;

    logic [LONG_LOG-1:0] phase_q;
    logic [LONG_LOG-1:0] limit;

    // Pick the terminal phase for the selected division.
    always_comb begin
        case (sel)
            PS_DIV16: limit = SHORT_LIM;
            default:  limit = LONG_LIM;
        endcase
    end

    // Raise a tick when the phase reaches its terminal value.
    always_comb begin
        tick = run && !restart && ((sel == PS_DIV1) || (phase_q == limit));
    end

    // Advance the phase, zeroing it on restart, idle or tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + LONG_LOG'(1);
        end
    end

endmodule

// File: rtl/qdt_channel.sv
// One down-counting timer channel with its load, control and
// background-load registers and its own prescaler.
// Assumes at most one of the write strobes is high in a cycle.
// Emits a one-cycle event on each terminal count.
module qdt_channel
    import qdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int NARROW_W  = 16,
    parameter int SHORT_LOG = 4,
    parameter int LONG_LOG  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic             wr_bgl,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] value_o,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] bgl_o,
    output logic             event_o
);

    localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'({NARROW_W{1'b1}});
    localparam logic [CNT_W-1:0] WIDE_MASK   = '1;

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] bgl_q;
    logic [CNT_W-1:0] cur_q;
    logic [CNT_W-1:0] width_mask;
    logic [CNT_W-1:0] cur_m;
    logic             at_zero;
    logic             at_one;
    logic             restart;
    logic             tick;
    logic             advance;

    // View the write data as a control word.
    always_comb begin
        ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Restart the divider when the channel turns on or its rate changes.
    always_comb begin
        restart = wr_ctrl &&
                  ((ctrl_new.en && !ctrl_q.en) || (ctrl_new.presc != ctrl_q.presc));
    end

    qdt_prescaler #(
        .SHORT_LOG (SHORT_LOG),
        .LONG_LOG  (LONG_LOG)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.en),
        .restart (restart),
        .sel     (ctrl_q.presc),
        .tick    (tick)
    );

    // Decode the active count width and the count's terminal states.
    always_comb begin
        width_mask = ctrl_q.wide ? WIDE_MASK : NARROW_MASK;
        cur_m      = cur_q & width_mask;
        at_zero    = (cur_m == '0);
        at_one     = (cur_m == CNT_W'(1));
    end

    // Decide whether this tick moves the count and whether it ends a cycle.
    always_comb begin
        advance = tick && !(ctrl_q.oneshot && at_zero);
        event_o = tick && !wr_load && (ctrl_q.oneshot ? at_one : at_zero);
    end

    // Hold the control word as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_new;
        end
    end

    // Hold the last written load value for readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (wr_load) begin
            load_q <= wdata;
        end
    end

    // Track the background-load value from either load or background writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bgl_q <= '0;
        end else if (wr_load || wr_bgl) begin
            bgl_q <= wdata;
        end
    end

    // Count down, wrap, reload or stop according to the mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (wr_load) begin
            cur_q <= wdata & width_mask;
        end else if (advance) begin
            if (at_zero) begin
                cur_q <= ctrl_q.periodic ? (bgl_q & width_mask) : width_mask;
            end else begin
                cur_q <= cur_m - CNT_W'(1);
            end
        end
    end

    assign load_o  = load_q;
    assign value_o = cur_m;
    assign ctrl_o  = ctrl_q;
    assign bgl_o   = bgl_q;

endmodule

// File: rtl/qdt_irq_ctrl.sv
// Shared interrupt controller: mask register, sticky raw bits set by
// channel events, write-one-to-clear, and a combined output.
// Assumes events are one-cycle pulses; an event beats a clear on the same edge.
module qdt_irq_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask,
    input  logic              wr_clear,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] events,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] masked_o,
    output logic              irq_o
);

    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] raw_q;
    logic [NUM_CH-1:0] clear_bits;

    // Select the bits dropped by a clear write.
    always_comb begin
        clear_bits = wr_clear ? wdata : '0;
    end

    // Hold the mask as written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= wdata;
        end
    end

    // Keep raw bits sticky, clearing on request unless an event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clear_bits) | events;
        end
    end

    // Gate raw bits with the mask and merge them into one line.
    always_comb begin
        masked_o = raw_q & mask_q;
        irq_o    = |masked_o;
    end

    assign mask_o = mask_q;
    assign raw_o  = raw_q;

endmodule

// File: rtl/qdt_bus_decode.sv
// Register bus decoder and read multiplexer.
// Group 0 of four words holds the interrupt registers; group g+1 holds
// channel g. Assumes 2**(ADDR_W-2) > NUM_CH. Unmapped words read zero.
module qdt_bus_decode
    import qdt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic                             bus_we,
    input  logic [NUM_CH-1:0]                irq_mask,
    input  logic [NUM_CH-1:0]                irq_raw,
    input  logic [NUM_CH-1:0]                irq_masked,
    input  logic [NUM_CH-1:0][DATA_W-1:0]    ch_load,
    input  logic [NUM_CH-1:0][DATA_W-1:0]    ch_value,
    input  logic [NUM_CH-1:0][CTRL_W-1:0]    ch_ctrl,
    input  logic [NUM_CH-1:0][DATA_W-1:0]    ch_bgl,
    output logic                             wr_mask,
    output logic                             wr_clear,
    output logic [NUM_CH-1:0]                wr_load,
    output logic [NUM_CH-1:0]                wr_ctrl,
    output logic [NUM_CH-1:0]                wr_bgl,
    output logic [DATA_W-1:0]                bus_rdata
);

    localparam int GRP_W = ADDR_W - 2;

    logic [GRP_W-1:0] group;
    logic [1:0]       word;
    logic             irq_hit;

    // Split the word index into group and word-in-group.
    always_comb begin
        group   = bus_addr[ADDR_W-1:2];
        word    = bus_addr[1:0];
        irq_hit = (group == '0);
    end

    // Form the interrupt register write strobes.
    always_comb begin
        wr_mask  = bus_we && irq_hit && (word == IRQ_MASK);
        wr_clear = bus_we && irq_hit && (word == IRQ_CLEAR);
    end

    // Form per-channel write strobes, one decoder per channel group.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        logic hit;
        always_comb begin
            hit        = bus_we && (group == GRP_W'(g + 1));
            wr_load[g] = hit && (word == REG_LOAD);
            wr_ctrl[g] = hit && (word == REG_CTRL);
            wr_bgl[g]  = hit && (word == REG_BGL);
        end
    end

    // Return the addressed register, zero for unmapped or write-only words.
    always_comb begin
        bus_rdata = '0;
        if (irq_hit) begin
            case (word)
                IRQ_MASK:  bus_rdata = DATA_W'(irq_mask);
                IRQ_RAW:   bus_rdata = DATA_W'(irq_raw);
                IRQ_MSTAT: bus_rdata = DATA_W'(irq_masked);
                default:   bus_rdata = '0;
            endcase
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (group == GRP_W'(c + 1)) begin
                case (word)
                    REG_LOAD:  bus_rdata = ch_load[c];
                    REG_VALUE: bus_rdata = ch_value[c];
                    REG_CTRL:  bus_rdata = DATA_W'(ch_ctrl[c]);
                    default:   bus_rdata = ch_bgl[c];
                endcase
            end
        end
    end

endmodule

// File: rtl/quad_down_timer.sv
// Top of the four-channel down-counting timer.
// Ties the bus decoder, the channels and the interrupt controller
// together. Assumes one clock for bus and counters and a synchronous
// active-low reset.
module quad_down_timer
    import qdt_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6,
    parameter int NARROW_W  = 16,
    parameter int SHORT_LOG = 4,
    parameter int LONG_LOG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic                          wr_mask;
    logic                          wr_clear;
    logic [NUM_CH-1:0]             wr_load;
    logic [NUM_CH-1:0]             wr_ctrl;
    logic [NUM_CH-1:0]             wr_bgl;
    logic [NUM_CH-1:0]             irq_mask;
    logic [NUM_CH-1:0]             irq_raw;
    logic [NUM_CH-1:0]             irq_masked;
    logic [NUM_CH-1:0]             ch_event;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_load;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_value;
    logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_bgl;

    qdt_bus_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .irq_mask   (irq_mask),
        .irq_raw    (irq_raw),
        .irq_masked (irq_masked),
        .ch_load    (ch_load),
        .ch_value   (ch_value),
        .ch_ctrl    (ch_ctrl),
        .ch_bgl     (ch_bgl),
        .wr_mask    (wr_mask),
        .wr_clear   (wr_clear),
        .wr_load    (wr_load),
        .wr_ctrl    (wr_ctrl),
        .wr_bgl     (wr_bgl),
        .bus_rdata  (bus_rdata)
    );

    // One counter channel per group.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ctrl_t ctrl_s;

        qdt_channel #(
            .CNT_W     (DATA_W),
            .NARROW_W  (NARROW_W),
            .SHORT_LOG (SHORT_LOG),
            .LONG_LOG  (LONG_LOG)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_load (wr_load[g]),
            .wr_ctrl (wr_ctrl[g]),
            .wr_bgl  (wr_bgl[g]),
            .wdata   (bus_wdata),
            .load_o  (ch_load[g]),
            .value_o (ch_value[g]),
            .ctrl_o  (ctrl_s),
            .bgl_o   (ch_bgl[g]),
            .event_o (ch_event[g])
        );

        assign ch_ctrl[g] = ctrl_s;
    end

    qdt_irq_ctrl #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mask  (wr_mask),
        .wr_clear (wr_clear),
        .wdata    (bus_wdata[NUM_CH-1:0]),
        .events   (ch_event),
        .mask_o   (irq_mask),
        .raw_o    (irq_raw),
        .masked_o (irq_masked),
        .irq_o    (irq_out)
    );

endmodule

// File: rtl/qdt_checker.sv
// Property checker for the four-channel timer, bound to the top module.
// Relates channel events, control bits and the interrupt state over time.
module qdt_checker #(
    parameter int NUM_CH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    irq_out,
    input logic [NUM_CH-1:0]       raw_q,
    input logic [NUM_CH-1:0]       mask_q,
    input logic [NUM_CH-1:0]       ch_ev,
    input logic [NUM_CH-1:0][7:0]  ch_ctrl
);

    // R1: reset empties the interrupt state and the output.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0 && mask_q == '0 && !irq_out));

    // R11: the output needs a pending raw bit.
    a_r11_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (raw_q != '0));

    // R11: a fully closed mask keeps the output low.
    a_r11_closed_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_out);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R12: a terminal count leaves its raw bit set, even against a clear.
        a_r12_event_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
            ch_ev[i] |=> raw_q[i]);

        // R12: a raw bit only rises after its channel's event.
        a_r12_raw_rise_from_event: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raw_q[i]) |-> $past(ch_ev[i]));

        // R5: a disabled channel raises no event.
        a_r5_idle_no_event: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_ctrl[i][7] |-> !ch_ev[i]);

        // R10: a one-shot event is not followed by another while one-shot holds.
        a_r10_oneshot_single: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ev[i] && ch_ctrl[i][0]) |=> (!ch_ev[i] || !ch_ctrl[i][0]));
    end

endmodule

bind quad_down_timer qdt_checker #(
    .NUM_CH (NUM_CH)
) u_qdt_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_out (irq_out),
    .raw_q   (irq_raw),
    .mask_q  (irq_mask),
    .ch_ev   (ch_event),
    .ch_ctrl (ch_ctrl)
);

// File: tb/quad_down_timer_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random
// channel runs compared with reference functions.
module quad_down_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    quad_down_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_out   (irq)
    );

    // Word index of register r in channel c's group.
    function automatic logic [5:0] cw(int c, int r);
        return 6'(4 + 4 * c + r);
    endfunction

    // Expected count after n ticks from load value ld (mode 0 free, 1 periodic, 2 one-shot).
    function automatic logic [31:0] exp_value(int mode, bit wide, longint ld, longint bg, longint n);
        longint m;
        longint top = wide ? 64'hFFFF_FFFF : 64'hFFFF;
        ld = ld & top;
        bg = bg & top;
        if (mode == 2) return (n >= ld) ? 32'd0 : 32'(ld - n);
        if (n <= ld) return 32'(ld - n);
        m = n - ld - 1;
        if (mode == 0) return 32'(top - (m % (top + 1)));
        return 32'(bg - (m % (bg + 1)));
    endfunction

    // Expected raw bit after n ticks.
    function automatic bit exp_raw(int mode, longint ld, longint n);
        if (mode == 2) return (ld != 0) && (n >= ld);
        return n >= ld + 1;
    endfunction

    task automatic wr(logic [5:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(string tag, logic [5:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    initial begin
        logic [31:0] d;
        int unsigned seed;
        repeat (3) @(negedge clk);

        // R1: reset state of every register and the output.
        chk("R1 irq_out", 32'(irq), 32'd0);
        chk_rd("R1 mask", 6'd0, 32'd0);
        chk_rd("R1 raw", 6'd1, 32'd0);
        chk_rd("R1 masked", 6'd2, 32'd0);
        for (int c = 0; c < 4; c++) begin
            chk_rd("R1 value", cw(c, 1), 32'd0);
            chk_rd("R1 ctrl", cw(c, 2), 32'd0);
        end
        rst_n = 1'b1;
        idle(1);

        // R2 R3 R7: register group placement, readback and width cut.
        wr(cw(2, 2), 32'h02);
        wr(cw(2, 0), 32'h1234_5678);
        chk_rd("R2 load readback", cw(2, 0), 32'h1234_5678);
        chk_rd("R3 value on load", cw(2, 1), 32'h1234_5678);
        chk_rd("R3 bgl follows load", cw(2, 3), 32'h1234_5678);
        chk_rd("R2 ctrl readback", cw(2, 2), 32'h02);
        wr(cw(2, 2), 32'h00);
        chk_rd("R7 narrow value", cw(2, 1), 32'h5678);
        wr(cw(2, 0), 32'hABCD_EF01);
        chk_rd("R7 narrow load", cw(2, 1), 32'hEF01);

        // R4 R9 R5: background load only at the next periodic reload.
        wr(cw(2, 2), 32'h02);
        wr(cw(2, 0), 32'd3);
        wr(cw(2, 3), 32'd5);
        chk_rd("R4 value untouched", cw(2, 1), 32'd3);
        chk_rd("R4 bgl readback", cw(2, 3), 32'd5);
        chk_rd("R4 load kept", cw(2, 0), 32'd3);
        wr(cw(2, 2), 32'hC2);
        idle(3);
        chk_rd("R9 at zero", cw(2, 1), 32'd0);
        rd(6'd1, d); chk("R9 raw before reload", 32'(d[2]), 32'd0);
        idle(1);
        chk_rd("R9 reload from bgl", cw(2, 1), 32'd5);
        rd(6'd1, d); chk("R9 raw at reload", 32'(d[2]), 32'd1);
        wr(cw(2, 2), 32'h42);
        chk_rd("R5 last tick on disable", cw(2, 1), 32'd4);
        idle(5);
        chk_rd("R5 holds when off", cw(2, 1), 32'd4);

        // R8: 16-bit free-running wrap.
        wr(cw(0, 2), 32'h00);
        wr(6'd3, 32'h1);
        wr(cw(0, 0), 32'd2);
        wr(cw(0, 2), 32'h80);
        idle(2);
        chk_rd("R8 at zero", cw(0, 1), 32'd0);
        idle(1);
        chk_rd("R8 wrap to ones", cw(0, 1), 32'hFFFF);
        rd(6'd1, d); chk("R8 raw on wrap", 32'(d[0]), 32'd1);
        idle(1);
        chk_rd("R8 keeps counting", cw(0, 1), 32'hFFFE);

        // R10: one-shot stops at zero, single interrupt, control unchanged.
        wr(cw(1, 2), 32'h02);
        wr(6'd3, 32'h2);
        wr(cw(1, 0), 32'd3);
        wr(cw(1, 2), 32'h83);
        idle(2);
        chk_rd("R10 before end", cw(1, 1), 32'd1);
        rd(6'd1, d); chk("R10 raw before end", 32'(d[1]), 32'd0);
        idle(1);
        chk_rd("R10 end at zero", cw(1, 1), 32'd0);
        rd(6'd1, d); chk("R10 raw at end", 32'(d[1]), 32'd1);
        wr(6'd3, 32'h2);
        idle(10);
        chk_rd("R10 stays zero", cw(1, 1), 32'd0);
        rd(6'd1, d); chk("R10 no second event", 32'(d[1]), 32'd0);
        chk_rd("R10 ctrl unchanged", cw(1, 2), 32'h83);

        // R11: mask, masked status and output.
        chk_rd("R11 raw set", 6'd1, 32'h5);
        wr(6'd0, 32'h2);
        chk_rd("R11 mask readback", 6'd0, 32'h2);
        chk_rd("R11 masked none", 6'd2, 32'h0);
        chk("R11 irq low", 32'(irq), 32'd0);
        wr(6'd0, 32'h1);
        chk_rd("R11 masked one", 6'd2, 32'h1);
        chk("R11 irq high", 32'(irq), 32'd1);
        wr(cw(0, 2), 32'h00);
        wr(6'd3, 32'h1);
        chk("R11 irq after clear", 32'(irq), 32'd0);
        wr(6'd0, 32'h0);

        // R12: event on the clear edge wins; clear works otherwise.
        wr(cw(3, 2), 32'h02);
        wr(cw(3, 0), 32'd0);
        wr(cw(3, 2), 32'hC2);
        wr(6'd3, 32'h8);
        rd(6'd1, d); chk("R12 event beats clear", 32'(d[3]), 32'd1);
        wr(cw(3, 2), 32'h02);
        wr(6'd3, 32'h8);
        rd(6'd1, d); chk("R12 clear drops bit", 32'(d[3]), 32'd0);
        chk_rd("R12 clear reads zero", 6'd3, 32'd0);

        // R6: divide by 16, then 256, then the spare code.
        wr(cw(1, 2), 32'h02);
        wr(cw(1, 0), 32'd100);
        wr(cw(1, 2), 32'h86);
        idle(15);
        chk_rd("R6 div16 edge 15", cw(1, 1), 32'd100);
        idle(1);
        chk_rd("R6 div16 edge 16", cw(1, 1), 32'd99);
        idle(16);
        chk_rd("R6 div16 edge 32", cw(1, 1), 32'd98);
        wr(cw(1, 2), 32'h8A);
        idle(255);
        chk_rd("R6 div256 edge 255", cw(1, 1), 32'd98);
        idle(1);
        chk_rd("R6 div256 edge 256", cw(1, 1), 32'd97);
        wr(cw(1, 2), 32'h8E);
        idle(255);
        chk_rd("R6 spare edge 255", cw(1, 1), 32'd97);
        idle(1);
        chk_rd("R6 spare edge 256", cw(1, 1), 32'd96);

        // R3: load while running takes effect at once.
        wr(cw(1, 0), 32'd7);
        chk_rd("R3 load while running", cw(1, 1), 32'd7);

        // R5 R6 R8 R9 R10: seeded random runs at full rate.
        seed = 32'h5EED;
        void'($urandom(seed));
        for (int it = 0; it < 40; it++) begin
            int c = int'($urandom % 4);
            int mode = int'($urandom % 3);
            bit wide = 1'($urandom % 2);
            longint ld = longint'($urandom % 40);
            longint bg = longint'($urandom % 12);
            longint n = longint'($urandom % 120) + 1;
            logic [31:0] cv;
            cv = 32'h80 | (mode == 1 ? 32'h40 : 32'h0) | (wide ? 32'h2 : 32'h0) |
                 (mode == 2 ? 32'h1 : 32'h0);
            wr(cw(c, 2), 32'h0);
            wr(6'd3, 32'(1 << c));
            wr(cw(c, 0), 32'(ld));
            wr(cw(c, 3), 32'(bg));
            wr(cw(c, 2), cv);
            idle(int'(n));
            chk_rd("R8/R9/R10 random value", cw(c, 1), exp_value(mode, wide, ld, bg, n));
            rd(6'd1, d);
            chk("R5 random raw", 32'(d[c]), 32'(exp_raw(mode, ld, n)));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule